// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block is a bank of event counters for performance monitoring. It has a small register interface with 32-bit data. There are four physical counters of 32 bits each. A per-counter mode bit splits any of them into two independent 16-bit halves, so software can use up to eight logical counters. Each logical counter has a strobe input, and the counter advances by one for every cycle in which its strobe is high while the monitor is enabled.

A software write to a counter does not change the live count. The value is held in a staging latch until software writes the control register with its enable bit set. That write copies every staged value into its live counter at once, and it does so even if the monitor is already running. A counter that wraps past its maximum value raises an overflow bit in a status word. Reading the status word returns the pending bits and clears them in the same access. Writing the status word sets the interrupt mask. Eight general-purpose counter-control words, one per logical counter, are also stored for the event-selection logic that sits outside this block.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset the enable bit, all mode bits, all counters, all staging latches, the status bits, the mask and `irq` are zero. Reads of the control word, the status word and every counter return 0.
- R2: The word map uses word addresses. The control word is at 0 and the status word is at 1. Logical counters 0..7 are at 8..15 and counter-control words 0..7 are at 16..23. Any other address reads as 0, and writes to it have no effect. In 32-bit mode, physical counter p advances on `evt[p]`. `evt[p+4]` is ignored in that mode, and logical counters p and p+4 both read the full 32-bit value.
- R3: In 16-bit mode (control bit 8+p set), logical counter p is bits 31:16 of physical counter p and advances on `evt[p]`. Logical counter p+4 is bits 15:0 and advances on `evt[p+4]`. A half never carries into the other half. Reads of a half return it zero-extended.
- R4: A counter write loads only the staging latch of that physical counter. The live counter keeps counting from its old value. While a write is pending, a read returns the staged value.
- R5: A control write with bit 0 set loads every pending staged value into its live counter, even if the monitor is already enabled. A strobe in that same cycle is dropped for the counters that load. In 16-bit mode, a half-write merges with the newest value of the other half.
- R6: While bit 0 of the control word is 0, no counter changes on strobes, and the counter values are kept.
- R7: When a 32-bit counter wraps from all ones to zero, it sets status bit p. In 16-bit mode, a wrap of the upper half sets bit p and a wrap of the lower half sets bit p+4.
- R8: Reading the status word returns the overflow bits in bits 7:0 and clears them. A bit that is set in the same cycle as the clearing read stays pending.
- R9: A status write loads the interrupt mask from bits 7:0. `irq` is high exactly when some status bit and its mask bit are both set, and it changes in the same cycle as the status bits. A mask of zero keeps `irq` low.
- R10: Each of the eight counter-control words stores a full 32-bit value and reads it back.
- R11: The control word reads back bit 0 (enable) and bits 11:8 (per-counter 16-bit mode). All other bits read as 0.
- R12: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| evt | input | 8 | Per-logical-counter increment strobes |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Two functions can land on the same edge: a counter wrap that sets a status bit, and a status read that clears the status bits. The bench loads a counter with all ones and enables the monitor. It then raises that counter's strobe in the same cycle as a status read. The read itself must return the status from before that edge, with the new bit absent. A second read must return the new bit, which shows it was kept. A third read must return zero. A sweep over all sixteen mode combinations also runs both halves of each split counter across the 16-bit wrap point with different strobe counts. Against the arithmetic expectations, this judges both the absence of carry between the halves and the overflow bits that result.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  // Fixed word map (word addresses)
  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int CTR_BASE  = 8;   // aligned to the logical counter count
  localparam int CFG_BASE  = 16;  // aligned to the logical counter count
  // Control word fields
  localparam int EN_BIT    = 0;
  localparam int SPLIT_LSB = 8;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_REG  = 2'd1,
    RS_CFG  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             split_i,
  input  logic             inc_hi_i,
  input  logic             inc_lo_i,
  input  logic             wr_i,
  input  logic             wr_lo_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CTR_W-1:0] view_o,
  output logic             ovf_hi_o,
  output logic             ovf_lo_o
);
  localparam int HALF = CTR_W / 2;
  localparam logic [CTR_W-1:0] ONE_W = CTR_W'(1);
  localparam logic [HALF-1:0]  ONE_H = HALF'(1);

  logic [CTR_W-1:0] live_q, latch_q, live_n, newest, merged;
  logic             pend_q, load, up_inc, lo_inc;

  assign load   = commit_i && pend_q;
  assign newest = pend_q ? latch_q : live_q;
  assign view_o = newest;
  assign up_inc = en_i && inc_hi_i && !load;
  assign lo_inc = en_i && split_i && inc_lo_i && !load;

  // Staged value: a half write keeps the newest copy of the other half
  always_comb begin
    if (!split_i)     merged = wdata_i;
    else if (wr_lo_i) merged = {newest[CTR_W-1:HALF], wdata_i[HALF-1:0]};
    else              merged = {wdata_i[HALF-1:0], newest[HALF-1:0]};
  end

  always_comb begin
    live_n   = live_q;
    ovf_hi_o = 1'b0;
    ovf_lo_o = 1'b0;
    if (split_i) begin
      if (up_inc) live_n[CTR_W-1:HALF] = live_q[CTR_W-1:HALF] + ONE_H;
      if (lo_inc) live_n[HALF-1:0]     = live_q[HALF-1:0] + ONE_H;
      ovf_hi_o = up_inc && (&live_q[CTR_W-1:HALF]);
      ovf_lo_o = lo_inc && (&live_q[HALF-1:0]);
    end else begin
      if (up_inc) live_n = live_q + ONE_W;
      ovf_hi_o = up_inc && (&live_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (load) live_q <= latch_q;
      else      live_q <= live_n;
      if (commit_i) pend_q <= 1'b0;
      if (wr_i) begin
        latch_q <= merged;
        pend_q  <= 1'b1;
      end
    end
  end

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load) |=> $stable(live_q));

  // R3
  half_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    (split_i && !inc_hi_i && !load) |=> $stable(live_q[CTR_W-1:HALF]));

  // R5
  commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !wr_i) |=> !pend_q);

  // R7
  wrap_full_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !split_i && inc_hi_i && !load && (&live_q)) |=> (live_q == '0));
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
  parameter int NUM_LOG = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOG-1:0] set_i,
  input  logic               rd_clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LOG-1:0] mask_i,
  output logic [NUM_LOG-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_LOG-1:0] status_q, status_n, mask_q, mask_n;
  logic               irq_q;

  // A bit set on the clearing edge survives the clear
  assign status_n = (rd_clr_i ? '0 : status_q) | set_i;
  assign mask_n   = mask_wr_i ? mask_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_n & mask_n);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R8
  keep_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && set_i == '0) |=> (status_q == '0));

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/pcb_cfg_mem.sv
module pcb_cfg_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [WIDTH-1:0]         wdata_i,
  input  logic                     re_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [WIDTH-1:0]         rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // Plain synchronous array with no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int NUM_PHYS = 4,
  parameter int CTR_W    = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CTR_W-1:0]      wdata,
  output logic [CTR_W-1:0]      rdata,
  input  logic [2*NUM_PHYS-1:0] evt,
  output logic                  irq
);
  import pcb_pkg::*;

  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int LOG_W   = $clog2(NUM_LOG);
  localparam int PHYS_W  = $clog2(NUM_PHYS);
  localparam int HALF    = CTR_W / 2;
  localparam int PAGE_W  = ADDR_W - LOG_W;
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(A_STAT);
  localparam logic [PAGE_W-1:0] CTR_PAGE = PAGE_W'(CTR_BASE >> LOG_W);
  localparam logic [PAGE_W-1:0] CFG_PAGE = PAGE_W'(CFG_BASE >> LOG_W);

  // Control state
  logic                en_q;
  logic [NUM_PHYS-1:0] split_q;

  // Decode
  logic              ctrl_wr, commit, stat_rd, stat_wr, ctr_hit, cfg_hit;
  logic [LOG_W-1:0]  log_idx;
  logic [PHYS_W-1:0] phys_idx;
  logic              sel_lo;

  assign ctrl_wr  = wr_en && (addr == CTRL_A);
  assign commit   = ctrl_wr && wdata[EN_BIT];
  assign stat_rd  = rd_en && (addr == STAT_A);
  assign stat_wr  = wr_en && (addr == STAT_A);
  assign ctr_hit  = (addr[ADDR_W-1:LOG_W] == CTR_PAGE);
  assign cfg_hit  = (addr[ADDR_W-1:LOG_W] == CFG_PAGE);
  assign log_idx  = addr[LOG_W-1:0];
  assign phys_idx = log_idx[PHYS_W-1:0];
  assign sel_lo   = log_idx[LOG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      split_q <= '0;
    end else if (ctrl_wr) begin
      en_q    <= wdata[EN_BIT];
      split_q <= wdata[SPLIT_LSB +: NUM_PHYS];
    end
  end

  // Physical counters
  logic [CTR_W-1:0]   view [NUM_PHYS];
  logic [NUM_LOG-1:0] ovf_set;
  logic [NUM_LOG-1:0] status;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_ctr
    logic wr_this;
    assign wr_this = wr_en && ctr_hit && (phys_idx == PHYS_W'(p));
    pcb_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .en_i     (en_q),
      .split_i  (split_q[p]),
      .inc_hi_i (evt[p]),
      .inc_lo_i (evt[p+NUM_PHYS]),
      .wr_i     (wr_this),
      .wr_lo_i  (sel_lo),
      .wdata_i  (wdata),
      .commit_i (commit),
      .view_o   (view[p]),
      .ovf_hi_o (ovf_set[p]),
      .ovf_lo_o (ovf_set[p+NUM_PHYS])
    );
  end

  pcb_status #(.NUM_LOG(NUM_LOG)) u_status (
    .clk       (clk),
    .rst       (rst),
    .set_i     (ovf_set),
    .rd_clr_i  (stat_rd),
    .mask_wr_i (stat_wr),
    .mask_i    (wdata[NUM_LOG-1:0]),
    .status_o  (status),
    .irq_o     (irq)
  );

  logic [CTR_W-1:0] cfg_rd;

  pcb_cfg_mem #(.DEPTH(NUM_LOG), .WIDTH(CTR_W)) u_cfg (
    .clk     (clk),
    .we_i    (wr_en && cfg_hit),
    .waddr_i (log_idx),
    .wdata_i (wdata),
    .re_i    (rd_en && cfg_hit),
    .raddr_i (log_idx),
    .rdata_o (cfg_rd)
  );

  // Read path
  logic [CTR_W-1:0] rd_view, reg_val, reg_rd_q;
  rd_src_e          src, rd_src_q;

  assign rd_view = view[phys_idx];

  always_comb begin
    reg_val = '0;
    src     = RS_NONE;
    if (addr == CTRL_A) begin
      src             = RS_REG;
      reg_val[EN_BIT] = en_q;
      for (int p = 0; p < NUM_PHYS; p++) reg_val[SPLIT_LSB+p] = split_q[p];
    end else if (addr == STAT_A) begin
      src                  = RS_REG;
      reg_val[NUM_LOG-1:0] = status;
    end else if (ctr_hit) begin
      src = RS_REG;
      if (split_q[phys_idx])
        reg_val[HALF-1:0] = sel_lo ? rd_view[HALF-1:0] : rd_view[CTR_W-1:HALF];
      else
        reg_val = rd_view;
    end else if (cfg_hit) begin
      src = RS_CFG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rd_src_q <= RS_NONE;
    end else if (rd_en) begin
      reg_rd_q <= reg_val;
      rd_src_q <= src;
    end
  end

  assign rdata = (rd_src_q == RS_CFG) ? cfg_rd : reg_rd_q;
endmodule

// File: tb/perf_ctr_bank_bench.sv
module perf_ctr_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_ctr_bank u_perf_ctr_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int l, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt[l] = 1'b1;
      @(negedge clk); evt[l] = 1'b0;
    end
  endtask

  function automatic logic [31:0] exp_ctr(input int m, input int l);
    int p = l % 4;
    int n = l + 3;
    if (((m >> p) & 1) == 1) begin
      if (l < 4) return (32'hFFFA + p + n) & 32'hFFFF;
      else       return (32'hFFF8 + p + n) & 32'hFFFF;
    end
    return 32'hFFFA + p + (p + 3);
  endfunction

  function automatic logic [31:0] exp_stat(input int m);
    logic [31:0] s = '0;
    for (int p = 0; p < 4; p++)
      if (((m >> p) & 1) == 1) begin
        if (32'hFFFA + p + (p + 3) > 32'hFFFF) s[p] = 1'b1;
        if (32'hFFF8 + p + (p + 7) > 32'hFFFF) s[p+4] = 1'b1;
      end
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(5'd0, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(5'd1, d); chk("R1 status", d, 32'h0);
    for (int l = 0; l < 8; l++) begin
      bus_rd(5'(8 + l), d); chk("R1 counter", d, 32'h0);
    end
    // R2 unmapped address
    bus_wr(5'd30, 32'hDEAD_BEEF);
    bus_rd(5'd30, d); chk("R2 unmapped", d, 32'h0);

    // R10 counter-control words
    for (int l = 0; l < 8; l++) bus_wr(5'(16 + l), 32'hC0DE_0000 | (l * 32'h111));
    for (int l = 0; l < 8; l++) begin
      bus_rd(5'(16 + l), d); chk("R10 cfg", d, 32'hC0DE_0000 | (l * 32'h111));
    end

    // R2 R3 R5 R7 sweep over all mode combinations
    for (int m = 0; m < 16; m++) begin
      bus_wr(5'd0, 32'(m) << 8);
      for (int p = 0; p < 4; p++) begin
        if (((m >> p) & 1) == 1) begin
          bus_wr(5'(8 + p), 32'hFFFA + p);
          bus_wr(5'(12 + p), 32'hFFF8 + p);
        end else begin
          bus_wr(5'(8 + p), 32'h0000_FFFA + p);
        end
      end
      bus_wr(5'd0, (32'(m) << 8) | 32'h1);
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        for (int l = 0; l < 8; l++) evt[l] = (k < l + 3);
      end
      @(negedge clk); evt = '0;
      bus_wr(5'd0, 32'(m) << 8);
      for (int l = 0; l < 8; l++) begin
        bus_rd(5'(8 + l), d);
        chk((((m >> (l % 4)) & 1) == 1) ? "R3 split count" : "R2 full count", d, exp_ctr(m, l));
      end
      bus_rd(5'd1, d); chk("R7 overflow bits", d, exp_stat(m));
    end

    // R4 staged write while running: live keeps counting old value
    bus_wr(5'd0, 32'h0);
    bus_wr(5'd8, 32'hFFFF_FFFE);
    bus_wr(5'd0, 32'h1);
    bus_wr(5'd8, 32'h0000_0010);
    bus_rd(5'd8, d); chk("R4 staged readback", d, 32'h10);
    pulse(0, 2);
    bus_rd(5'd1, d); chk("R4 live kept counting", d, 32'h1);
    bus_rd(5'd8, d); chk("R4 staged after events", d, 32'h10);
    // R5 commit while already enabled
    bus_wr(5'd0, 32'h1);
    pulse(0, 4);
    bus_rd(5'd8, d); chk("R5 commit while running", d, 32'h14);
    // R6 stop keeps value
    bus_wr(5'd0, 32'h0);
    pulse(0, 5);
    bus_rd(5'd8, d); chk("R6 stopped", d, 32'h14);
    bus_wr(5'd0, 32'h1);
    pulse(0, 1);
    bus_rd(5'd8, d); chk("R6 resumed", d, 32'h15);

    // R5 half-write merge, R3 layout
    bus_wr(5'd0, 32'h200);
    bus_wr(5'd9, 32'h0000_AAAA);
    bus_wr(5'd13, 32'h0000_5555);
    bus_rd(5'd9, d);  chk("R5 merge upper", d, 32'hAAAA);
    bus_rd(5'd13, d); chk("R5 merge lower", d, 32'h5555);
    bus_wr(5'd0, 32'h201);
    pulse(5, 2);
    bus_rd(5'd13, d); chk("R3 lower count", d, 32'h5557);
    bus_rd(5'd9, d);  chk("R3 upper untouched", d, 32'hAAAA);
    bus_wr(5'd0, 32'h0);
    bus_rd(5'd9, d);  chk("R3 half layout", d, 32'hAAAA_5557);

    // R8 set on the clearing edge
    bus_wr(5'd10, 32'hFFFF_FFFF);
    bus_wr(5'd0, 32'h1);
    bus_rd(5'd1, d);
    @(negedge clk); rd_en = 1'b1; addr = 5'd1; evt[2] = 1'b1;
    @(negedge clk); rd_en = 1'b0; evt = '0; d = rdata;
    chk("R8 collision read old", d, 32'h0);
    bus_rd(5'd1, d); chk("R8 collision kept", d, 32'h4);
    bus_rd(5'd1, d); chk("R8 cleared", d, 32'h0);

    // R9 mask and irq
    bus_wr(5'd1, 32'h08);
    bus_wr(5'd11, 32'hFFFF_FFFF);
    bus_wr(5'd0, 32'h1);
    chk("R9 irq idle", {31'b0, irq}, 32'h0);
    @(negedge clk); evt[3] = 1'b1;
    @(negedge clk); evt = '0;
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    bus_rd(5'd1, d); chk("R9 status bit3", d, 32'h8);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    bus_wr(5'd1, 32'h0);
    bus_wr(5'd11, 32'hFFFF_FFFF);
    bus_wr(5'd0, 32'h1);
    pulse(3, 1);
    chk("R9 masked off", {31'b0, irq}, 32'h0);
    bus_rd(5'd1, d); chk("R9 status still set", d, 32'h8);

    // R11 control readback, R12 hold
    bus_wr(5'd0, 32'h0000_0A01);
    bus_rd(5'd0, d); chk("R11 ctrl", d, 32'h0000_0A01);
    bus_wr(5'd0, 32'hFFFF_FFFE);
    bus_rd(5'd0, d); chk("R11 ctrl masked", d, 32'h0000_0F00);
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", rdata, 32'h0000_0F00);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule